// File: doc/BRIEF.md
# Age-Ordered Issue Selector with Register Wakeup

This block is the scheduling window of an out-of-order core. It holds a fixed number of waiting instructions. Each one carries a sequence number, an operation class and up to two physical source register tags. Each cycle it picks up to `W` instructions whose operands are available and whose functional unit is free, and it always prefers the oldest one. Renaming, register read and execution happen outside this block.

Selection works in two levels. Inside each operation class, the ready entry with the smallest sequence number is the head of that class. Each issue slot then takes the oldest of the class heads. Once a head is taken, the next-oldest entry of that class becomes the class head and competes for the following slot.

Source readiness comes from a small scoreboard that holds one ready bit per physical register. All registers share one index space: integer registers sit at the low indices and floating-point registers follow them. When an instruction that writes a register is inserted, that register's bit is cleared. A broadcast tag on the wakeup bus sets the bit again and marks every waiting consumer of that register as ready. A flush input removes every entry that is younger than a given sequence number.

Top module: `age_issue_queue`

## Requirements
- R1: After reset no slot is issued, `full` is low, `stall_cnt` is zero and every register is marked ready in the scoreboard.
- R2: An entry with an unproduced source is held until a matching wakeup tag arrives. If the wakeup is driven in the cycle before clock edge E, the entry is first seen issued after edge E+1.
- R3: Among ready entries, the one with the smallest sequence number issues first, whatever its class. Within a cycle, slot 0 holds the oldest issue and slot 1 the next.
- R4: At most `W` entries issue per cycle. Valid slots are filled from slot 0 upward. When a class head issues, the next entry of that class is ranked for the next slot in the same cycle.
- R5: An entry whose class bit in `fu_busy` is 1 is not issued in that cycle. Ready entries of classes that are not busy still issue past it.
- R6: `stall_cnt` increases by exactly one at every clock edge where at least one ready entry was held back by a busy unit. It saturates at its maximum.
- R7: While `flush_vld` is high, every entry with sequence number greater than `flush_seq` is removed and is not issued in that cycle. Entries with sequence numbers less than or equal to `flush_seq` remain.
- R8: `full` is high when all `N` entries are occupied. An insert while `full` is high is dropped. Issued entries free their slots, so `full` falls in the cycle after the issue edge.
- R9: Tags `0..NUM_INT-1` name integer registers and tags `NUM_INT..NUM_INT+NUM_FP-1` name floating-point registers. A wakeup of integer tag k does not ready a consumer of floating-point tag `NUM_INT+k`.
- R10: An insert with `ins_dst_vld` clears the ready bit of `ins_dst`, so later consumers of that register wait. A source whose tag is woken in the same cycle as its insert is taken as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | Insert request |
| ins_seq | input | SEQW | Sequence number of the inserted instruction |
| ins_cls | input | CLSW | Operation class of the inserted instruction |
| ins_src0_vld | input | 1 | First source is used |
| ins_src0 | input | TAGW | First source physical tag |
| ins_src1_vld | input | 1 | Second source is used |
| ins_src1 | input | TAGW | Second source physical tag |
| ins_dst_vld | input | 1 | Instruction writes a destination register |
| ins_dst | input | TAGW | Destination physical tag |
| wk_vld | input | NWAKE | Wakeup bus lane valid bits |
| wk_tag | input | NWAKE*TAGW | Wakeup tags, lane k at bits k*TAGW upward |
| fu_busy | input | NCLS | Functional unit busy flag per class |
| flush_vld | input | 1 | Remove entries younger than `flush_seq` |
| flush_seq | input | SEQW | Youngest sequence number that survives the flush |
| iss_vld | output | W | Issue slot valid bits, registered |
| iss_seq | output | W*SEQW | Issued sequence numbers, slot s at bits s*SEQW upward |
| iss_cls | output | W*CLSW | Issued operation classes per slot |
| full | output | 1 | All entries are occupied |
| stall_cnt | output | CNTW | Count of cycles in which a busy unit held back a ready entry |

## Verification
Two pairs of functions can act in the same cycle. The first pair is flush and issue. The bench holds two ready entries behind busy units, then frees the units in the same cycle that it flushes everything younger than the older entry. Only the older entry may come out, and the younger one must never appear later. The second pair is wakeup and insert. A consumer is inserted in the same cycle that the tag of its pending producer is broadcast, and the bench checks that the consumer still issues and is not left waiting for good. A scoreboard queue holds the issue order that the bench works out from sequence numbers, and every issued slot is popped and compared against it.

// File: rtl/iq_pkg.sv
package iq_pkg;

  // width of an index able to name n distinct values, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // a smaller sequence number is the older instruction
  function automatic logic is_older(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int NREG  = 64,
  parameter int NWAKE = 2,
  parameter int TAGW  = iq_pkg::idx_w(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_vld,
  input  logic [TAGW-1:0]        clr_tag,
  input  logic [NWAKE-1:0]       wk_vld,
  input  logic [NWAKE*TAGW-1:0]  wk_tag,
  input  logic [TAGW-1:0]        q0_tag,
  input  logic [TAGW-1:0]        q1_tag,
  output logic                   q0_rdy,
  output logic                   q1_rdy
);

  logic [NREG-1:0] rdy_q;
  logic [NREG-1:0] rdy_d;
  logic            q0_byp, q1_byp;

  always_comb begin
    rdy_d  = rdy_q;
    q0_byp = 1'b0;
    q1_byp = 1'b0;
    for (int w = 0; w < NWAKE; w++) begin
      if (wk_vld[w]) begin
        if (int'(wk_tag[w*TAGW +: TAGW]) < NREG) rdy_d[wk_tag[w*TAGW +: TAGW]] = 1'b1;
        if (wk_tag[w*TAGW +: TAGW] == q0_tag) q0_byp = 1'b1;
        if (wk_tag[w*TAGW +: TAGW] == q1_tag) q1_byp = 1'b1;
      end
    end
    // a newly recorded producer wins over a wakeup of the same register
    if (clr_vld && int'(clr_tag) < NREG) rdy_d[clr_tag] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= '1;
    else     rdy_q <= rdy_d;
  end

  assign q0_rdy = q0_byp | ((int'(q0_tag) < NREG) ? rdy_q[q0_tag] : 1'b0);
  assign q1_rdy = q1_byp | ((int'(q1_tag) < NREG) ? rdy_q[q1_tag] : 1'b0);

endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int N    = 8,
  parameter int W    = 2,
  parameter int NCLS = 4,
  parameter int SEQW = 16,
  parameter int IDXW = iq_pkg::idx_w(N),
  parameter int CLSW = iq_pkg::idx_w(NCLS)
) (
  input  logic [N-1:0]       cand,
  input  logic [N*SEQW-1:0]  seq,
  input  logic [N*CLSW-1:0]  cls,
  input  logic [NCLS-1:0]    fu_busy,
  output logic [W-1:0]       pick_vld,
  output logic [W*IDXW-1:0]  pick_idx,
  output logic               blocked
);

  logic [N-1:0]          unit_free;
  logic [W:0][N-1:0]     taken;

  always_comb begin
    for (int i = 0; i < N; i++) unit_free[i] = ~fu_busy[cls[i*CLSW +: CLSW]];
  end

  assign blocked  = |(cand & ~unit_free);
  assign taken[0] = '0;

  for (genvar s = 0; s < W; s++) begin : g_slot
    logic [N-1:0]    elig;
    logic            hv [NCLS];
    logic [IDXW-1:0] hi [NCLS];
    logic [SEQW-1:0] hs [NCLS];
    logic            bv;
    logic [IDXW-1:0] bi;
    logic [SEQW-1:0] bs;

    always_comb begin
      elig = cand & unit_free & ~taken[s];
      // per-class head: oldest eligible entry of each class
      for (int c = 0; c < NCLS; c++) begin
        hv[c] = 1'b0;
        hi[c] = '0;
        hs[c] = '0;
        for (int i = 0; i < N; i++) begin
          if (elig[i] && cls[i*CLSW +: CLSW] == CLSW'(c) &&
              (!hv[c] || iq_pkg::is_older(64'(seq[i*SEQW +: SEQW]), 64'(hs[c])))) begin
            hv[c] = 1'b1;
            hi[c] = IDXW'(i);
            hs[c] = seq[i*SEQW +: SEQW];
          end
        end
      end
      // rank the class heads against each other
      bv = 1'b0;
      bi = '0;
      bs = '0;
      for (int c = 0; c < NCLS; c++) begin
        if (hv[c] && (!bv || iq_pkg::is_older(64'(hs[c]), 64'(bs)))) begin
          bv = 1'b1;
          bi = hi[c];
          bs = hs[c];
        end
      end
    end

    assign pick_vld[s]               = bv;
    assign pick_idx[s*IDXW +: IDXW]  = bi;
    assign taken[s+1]                = taken[s] | (bv ? (N'(1) << bi) : '0);
  end

endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int N       = 8,
  parameter int W       = 2,
  parameter int NCLS    = 4,
  parameter int SEQW    = 16,
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  parameter int NWAKE   = 2,
  parameter int CNTW    = 16,
  parameter int NREG    = NUM_INT + NUM_FP,
  parameter int TAGW    = iq_pkg::idx_w(NREG),
  parameter int CLSW    = iq_pkg::idx_w(NCLS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ins_vld,
  input  logic [SEQW-1:0]       ins_seq,
  input  logic [CLSW-1:0]       ins_cls,
  input  logic                  ins_src0_vld,
  input  logic [TAGW-1:0]       ins_src0,
  input  logic                  ins_src1_vld,
  input  logic [TAGW-1:0]       ins_src1,
  input  logic                  ins_dst_vld,
  input  logic [TAGW-1:0]       ins_dst,
  input  logic [NWAKE-1:0]      wk_vld,
  input  logic [NWAKE*TAGW-1:0] wk_tag,
  input  logic [NCLS-1:0]       fu_busy,
  input  logic                  flush_vld,
  input  logic [SEQW-1:0]       flush_seq,
  output logic [W-1:0]          iss_vld,
  output logic [W*SEQW-1:0]     iss_seq,
  output logic [W*CLSW-1:0]     iss_cls,
  output logic                  full,
  output logic [CNTW-1:0]       stall_cnt
);

  localparam int IDXW = iq_pkg::idx_w(N);

  // entry storage
  logic [N-1:0]    ent_vld;
  logic [N-1:0]    ent_r0, ent_r1;
  logic [SEQW-1:0] ent_seq [N];
  logic [CLSW-1:0] ent_cls [N];
  logic [TAGW-1:0] ent_t0  [N];
  logic [TAGW-1:0] ent_t1  [N];

  logic [N-1:0]        kill, cand, hit0, hit1, issued;
  logic [N*SEQW-1:0]   seq_flat;
  logic [N*CLSW-1:0]   cls_flat;
  logic                has_free, accept;
  logic [IDXW-1:0]     free_idx;
  logic                sb_r0, sb_r1;
  logic [W-1:0]        pick_vld;
  logic [W*IDXW-1:0]   pick_idx;
  logic                blocked;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        has_free = 1'b1;
        free_idx = IDXW'(i);
      end
    end
  end

  assign accept = ins_vld & has_free;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      kill[i] = flush_vld & ent_vld[i] & (ent_seq[i] > flush_seq);
      cand[i] = ent_vld[i] & ent_r0[i] & ent_r1[i] & ~kill[i];
      seq_flat[i*SEQW +: SEQW] = ent_seq[i];
      cls_flat[i*CLSW +: CLSW] = ent_cls[i];
      hit0[i] = 1'b0;
      hit1[i] = 1'b0;
      for (int w = 0; w < NWAKE; w++) begin
        if (wk_vld[w] && wk_tag[w*TAGW +: TAGW] == ent_t0[i]) hit0[i] = 1'b1;
        if (wk_vld[w] && wk_tag[w*TAGW +: TAGW] == ent_t1[i]) hit1[i] = 1'b1;
      end
    end
  end

  always_comb begin
    issued = '0;
    for (int s = 0; s < W; s++) begin
      if (pick_vld[s]) issued[pick_idx[s*IDXW +: IDXW]] = 1'b1;
    end
  end

  iq_scoreboard #(.NREG(NREG), .NWAKE(NWAKE), .TAGW(TAGW)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .clr_vld (accept & ins_dst_vld),
    .clr_tag (ins_dst),
    .wk_vld  (wk_vld),
    .wk_tag  (wk_tag),
    .q0_tag  (ins_src0),
    .q1_tag  (ins_src1),
    .q0_rdy  (sb_r0),
    .q1_rdy  (sb_r1)
  );

  iq_select #(.N(N), .W(W), .NCLS(NCLS), .SEQW(SEQW), .IDXW(IDXW), .CLSW(CLSW)) u_sel (
    .cand     (cand),
    .seq      (seq_flat),
    .cls      (cls_flat),
    .fu_busy  (fu_busy),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx),
    .blocked  (blocked)
  );

  // payload array: no reset, written per index
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (hit0[i]) ent_r0[i] <= 1'b1;
      if (hit1[i]) ent_r1[i] <= 1'b1;
    end
    if (accept) begin
      ent_seq[free_idx] <= ins_seq;
      ent_cls[free_idx] <= ins_cls;
      ent_t0[free_idx]  <= ins_src0;
      ent_t1[free_idx]  <= ins_src1;
      ent_r0[free_idx]  <= ~ins_src0_vld | sb_r0;
      ent_r1[free_idx]  <= ~ins_src1_vld | sb_r1;
    end
  end

  // occupancy, issue outputs and stall counter
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld   <= '0;
      iss_vld   <= '0;
      iss_seq   <= '0;
      iss_cls   <= '0;
      stall_cnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (issued[i] || kill[i]) ent_vld[i] <= 1'b0;
      end
      if (accept) ent_vld[free_idx] <= 1'b1;
      for (int s = 0; s < W; s++) begin
        iss_vld[s]                <= pick_vld[s];
        iss_seq[s*SEQW +: SEQW]   <= ent_seq[pick_idx[s*IDXW +: IDXW]];
        iss_cls[s*CLSW +: CLSW]   <= ent_cls[pick_idx[s*IDXW +: IDXW]];
      end
      if (blocked && stall_cnt != '1) stall_cnt <= stall_cnt + 1'b1;
    end
  end

  assign full = &ent_vld;

endmodule

// File: rtl/age_issue_queue_chk.sv
module age_issue_queue_chk #(
  parameter int W    = 2,
  parameter int NCLS = 4,
  parameter int SEQW = 16,
  parameter int CNTW = 16,
  parameter int CLSW = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      iss_vld,
  input logic [W*SEQW-1:0] iss_seq,
  input logic [W*CLSW-1:0] iss_cls,
  input logic [NCLS-1:0]   fu_busy,
  input logic              flush_vld,
  input logic [SEQW-1:0]   flush_seq,
  input logic              full,
  input logic [CNTW-1:0]   stall_cnt
);

  logic [NCLS-1:0] busy_q;
  logic            fl_q;
  logic [SEQW-1:0] fls_q;

  always_ff @(posedge clk) begin
    busy_q <= fu_busy;
    fl_q   <= flush_vld;
    fls_q  <= flush_seq;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (iss_vld == '0 && !full && stall_cnt == '0));

  // R4: slots fill from slot 0 upward
  a_r4_packed_slots: assert property (@(posedge clk) disable iff (rst)
    (iss_vld & (iss_vld + 1'b1)) == '0);

  // R6
  a_r6_stall_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (CNTW'(stall_cnt - $past(stall_cnt)) <= CNTW'(1)));

  for (genvar s = 0; s < W; s++) begin : g_chk
    // R5
    a_r5_no_busy_issue: assert property (@(posedge clk) disable iff (rst)
      iss_vld[s] |-> !busy_q[iss_cls[s*CLSW +: CLSW]]);
    // R7
    a_r7_no_flushed_issue: assert property (@(posedge clk) disable iff (rst)
      (iss_vld[s] && fl_q) |-> (iss_seq[s*SEQW +: SEQW] <= fls_q));
    if (s > 0) begin : g_ord
      // R3
      a_r3_slot_age_order: assert property (@(posedge clk) disable iff (rst)
        iss_vld[s] |-> (iss_vld[s-1] &&
          iss_seq[(s-1)*SEQW +: SEQW] < iss_seq[s*SEQW +: SEQW]));
    end
  end

endmodule

bind age_issue_queue age_issue_queue_chk #(
  .W(W), .NCLS(NCLS), .SEQW(SEQW), .CNTW(CNTW), .CLSW(CLSW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_vld   (iss_vld),
  .iss_seq   (iss_seq),
  .iss_cls   (iss_cls),
  .fu_busy   (fu_busy),
  .flush_vld (flush_vld),
  .flush_seq (flush_seq),
  .full      (full),
  .stall_cnt (stall_cnt)
);

// File: tb/sim_age_issue_queue.sv
`timescale 1ns/1ps
module sim_age_issue_queue;
  localparam int N = 8, W = 2, NCLS = 4, SEQW = 16, NUM_INT = 32, NUM_FP = 32;
  localparam int NWAKE = 2, CNTW = 16, TAGW = 6, CLSW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ins_vld = 0, ins_src0_vld = 0, ins_src1_vld = 0, ins_dst_vld = 0;
  logic [SEQW-1:0] ins_seq = '0, flush_seq = '0;
  logic [CLSW-1:0] ins_cls = '0;
  logic [TAGW-1:0] ins_src0 = '0, ins_src1 = '0, ins_dst = '0;
  logic [NWAKE-1:0] wk_vld = '0;
  logic [NWAKE*TAGW-1:0] wk_tag = '0;
  logic [NCLS-1:0] fu_busy = '0;
  logic flush_vld = 0;
  logic [W-1:0] iss_vld;
  logic [W*SEQW-1:0] iss_seq;
  logic [W*CLSW-1:0] iss_cls;
  logic full;
  logic [CNTW-1:0] stall_cnt;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  age_issue_queue #(.N(N), .W(W), .NCLS(NCLS), .SEQW(SEQW), .NUM_INT(NUM_INT),
                    .NUM_FP(NUM_FP), .NWAKE(NWAKE), .CNTW(CNTW)) u0 (
    .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_seq(ins_seq), .ins_cls(ins_cls),
    .ins_src0_vld(ins_src0_vld), .ins_src0(ins_src0), .ins_src1_vld(ins_src1_vld),
    .ins_src1(ins_src1), .ins_dst_vld(ins_dst_vld), .ins_dst(ins_dst),
    .wk_vld(wk_vld), .wk_tag(wk_tag), .fu_busy(fu_busy), .flush_vld(flush_vld),
    .flush_seq(flush_seq), .iss_vld(iss_vld), .iss_seq(iss_seq), .iss_cls(iss_cls),
    .full(full), .stall_cnt(stall_cnt));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every issued slot must match the head of the expected order
  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < W; s++) begin
        if (iss_vld[s]) begin
          if (exp_q.size() == 0) chk("R3 unexpected issue", int'(iss_seq[s*SEQW +: SEQW]), -1);
          else chk("R3 issue order", int'(iss_seq[s*SEQW +: SEQW]), exp_q.pop_front());
        end
      end
    end
  end

  // drivers are called right after a falling edge and return after the next one
  task automatic ins(input int sq, input int cl, input bit s0v, input int s0,
                     input bit dv, input int d);
    ins_vld = 1; ins_seq = SEQW'(sq); ins_cls = CLSW'(cl);
    ins_src0_vld = s0v; ins_src0 = TAGW'(s0); ins_src1_vld = 0;
    ins_dst_vld = dv; ins_dst = TAGW'(d);
    @(negedge clk);
    ins_vld = 0; ins_src0_vld = 0; ins_dst_vld = 0;
  endtask

  task automatic wake(input int t);
    wk_vld = 2'b01; wk_tag = '0; wk_tag[TAGW-1:0] = TAGW'(t);
    @(negedge clk);
    wk_vld = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 40 && exp_q.size() != 0; k++) @(negedge clk);
    idle(4);
    chk(req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 iss_vld", int'(iss_vld), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 stall_cnt", int'(stall_cnt), 0);

    // R3/R4/R6: collect behind busy units, then release
    fu_busy = 4'hF;
    ins(40, 1, 0, 0, 0, 0); ins(10, 2, 0, 0, 0, 0); ins(30, 2, 0, 0, 0, 0);
    ins(20, 0, 0, 0, 0, 0); ins(50, 3, 0, 0, 0, 0);
    c0 = int'(stall_cnt);
    idle(3);
    chk("R6 stall increments", int'(stall_cnt) - c0, 3);
    exp_q.push_back(10); exp_q.push_back(20); exp_q.push_back(30);
    exp_q.push_back(40); exp_q.push_back(50);
    fu_busy = '0;
    @(negedge clk);
    chk("R4 two issues per cycle", int'(iss_vld), 3);
    drain("R3 age order drained");
    c0 = int'(stall_cnt);
    idle(2);
    chk("R6 no increment when idle", int'(stall_cnt) - c0, 0);

    // R5: busy class held, free class bypasses
    fu_busy = 4'b0100;
    exp_q.push_back(70);
    ins(60, 2, 0, 0, 0, 0); ins(70, 1, 0, 0, 0, 0);
    idle(4);
    chk("R5 busy class held", exp_q.size(), 0);
    exp_q.push_back(60);
    fu_busy = '0;
    drain("R5 released");

    // R10/R2: producer clears tag 5, consumer waits for wakeup
    exp_q.push_back(100);
    ins(100, 0, 0, 0, 1, 5);
    ins(101, 1, 1, 5, 0, 0);
    idle(4);
    chk("R10 consumer waits", exp_q.size(), 0);
    exp_q.push_back(101);
    wake(5);
    chk("R2 not yet issued", int'(iss_vld), 0);
    @(negedge clk);
    chk("R2 issue after wakeup", int'(iss_vld[0]), 1);
    drain("R2 drained");

    // R9: FP tag NUM_INT+5 is distinct from integer tag 5
    exp_q.push_back(110); exp_q.push_back(112);
    ins(110, 0, 0, 0, 1, NUM_INT + 5);
    ins(111, 1, 1, NUM_INT + 5, 0, 0);
    ins(112, 2, 1, 5, 0, 0);
    idle(3);
    wake(5);
    idle(4);
    chk("R9 int wakeup leaves fp consumer", exp_q.size(), 0);
    exp_q.push_back(111);
    wake(NUM_INT + 5);
    drain("R9 fp wakeup");

    // R10: wakeup in the same cycle as the consumer insert
    exp_q.push_back(119); exp_q.push_back(120);
    ins(119, 0, 0, 0, 1, 9);
    wk_vld = 2'b10; wk_tag = '0; wk_tag[2*TAGW-1:TAGW] = TAGW'(9);
    ins(120, 3, 1, 9, 0, 0);
    wk_vld = '0;
    drain("R10 same-cycle wakeup");

    // R7: flush while held
    fu_busy = 4'hF;
    ins(200, 0, 0, 0, 0, 0); ins(201, 1, 0, 0, 0, 0);
    ins(202, 2, 0, 0, 0, 0); ins(203, 3, 0, 0, 0, 0);
    flush_vld = 1; flush_seq = 201;
    @(negedge clk);
    flush_vld = 0;
    exp_q.push_back(200); exp_q.push_back(201);
    fu_busy = '0;
    drain("R7 younger removed");

    // R7: flush in the same cycle as issue
    fu_busy = 4'hF;
    ins(300, 0, 0, 0, 0, 0); ins(301, 1, 0, 0, 0, 0);
    exp_q.push_back(300);
    fu_busy = '0; flush_vld = 1; flush_seq = 300;
    @(negedge clk);
    flush_vld = 0;
    chk("R7 same-cycle slot0", int'(iss_vld), 1);
    drain("R7 same-cycle flush");

    // R8: fill, drop insert while full, drain
    fu_busy = 4'hF;
    for (int k = 0; k < N; k++) ins(400 + k, k % NCLS, 0, 0, 0, 0);
    chk("R8 full set", int'(full), 1);
    ins(408, 0, 0, 0, 0, 0);
    chk("R8 still full", int'(full), 1);
    for (int k = 0; k < N; k++) exp_q.push_back(400 + k);
    fu_busy = '0;
    @(negedge clk);
    chk("R8 full falls after issue", int'(full), 0);
    drain("R8 dropped insert absent");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule